// File: doc/BRIEF.md
# Translation Unit Control and Fault Register Block

This block is the software-visible control plane of an address translation unit. A host reaches it through a simple 32-bit register bus: a write strobe, a read strobe, a byte offset and write data. Read data comes back one cycle after the read strobe. Through this bus, software can:

- turn the unit on, hold it, or turn it off;
- see whether it is held;
- program the page table base and a configuration word;
- request whole or single-page invalidations of cached translations;
- identify the hardware revision.

The translation datapath reports faults to the block as an eight-bit event vector with one accompanying address. The block records each event as a sticky interrupt status bit and stores the faulting address in one of four capture registers, chosen by the kind of fault. A fault forces the unit into the held state, where it stays until software writes a control command. The block drives the interrupt line, the mode outputs, the configuration fields and single-cycle invalidation pulses toward the translation logic. Software services a fault by reading the status and the captured address, clearing the status bits and writing the run command.

Top module: `xlt_ctl_regs`

## Requirements
- R1: After reset the control, status, configuration, page table base and interrupt status registers all read 0, and the run, held and interrupt outputs are low.
- R2: A write to offset 0x000 of 0x5 selects run mode, 0x7 selects held mode and 0x0 selects off mode. Any other value is ignored. Reading offset 0x000 returns the code of the current mode.
- R3: Status offset 0x008 bit 0 reads 1 exactly while the unit is held, and it is set in the cycle after a 0x7 control write.
- R4: Configuration offset 0x004 stores only the write-data bits under mask 0x0150FFFF. Bit 0 drives the replacement-policy output and bits [10:7] drive the 4-bit priority output.
- R5: The page table base at offset 0x014 stores and returns all 32 bits and is presented on its output.
- R6: A write to offset 0x00C with bit 0 set produces a one-cycle flush-all pulse in the cycle after the write. With bit 0 clear, the write produces no pulse.
- R7: A write to offset 0x010 with bit 0 set produces a one-cycle single-entry flush pulse, with the address output equal to write data bits [31:12] above twelve zero bits. With bit 0 clear, the write produces no pulse.
- R8: Fault event bits are sticky in interrupt status at offset 0x018, in this order: bit 0 page fault, 1 read multi-hit, 2 write multi-hit, 3 bus error, 4 read security, 5 read access, 6 write security, 7 write access. The interrupt output is high exactly when any status bit is set.
- R9: Writing offset 0x01C clears each status bit whose write-data bit is 1. A fault arriving in the same cycle as the clear keeps its bit set.
- R10: A fault captures its address as follows: page fault at 0x024; write-channel faults (bits 2, 6, 7) at 0x028; read-channel faults (bits 1, 4, 5) at 0x02C; bus error at 0x030.
- R11: Any fault event puts the unit in held mode on the next cycle, even if a control write occurs in the same cycle. The unit stays held until a run or off command is written.
- R12: Offset 0x034 returns the 4-bit major and 7-bit minor revision in bits [31:21] with zeros below, and writes to it are ignored.
- R13: The flush offsets, the clear offset and any unmapped offset read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wen | input | 1 | Register write strobe |
| reg_ren | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after reg_ren |
| fault_vld | input | NUM_FAULTS | One bit per fault type raised this cycle |
| fault_addr | input | DATA_W | Address associated with the raised faults |
| xlt_run | output | 1 | Unit is translating |
| xlt_held | output | 1 | Unit is held |
| pt_base | output | DATA_W | Page table base |
| cfg_lru | output | 1 | Replacement-policy select |
| cfg_qos | output | 4 | Priority value |
| flush_all | output | 1 | One-cycle invalidate-all pulse |
| flush_one | output | 1 | One-cycle single-entry invalidate pulse |
| flush_one_addr | output | DATA_W | Page-aligned address for flush_one |
| irq | output | 1 | Fault interrupt |

## Verification
The bench first targets the fault path. It raises a fault while running and checks that the unit stays held for many cycles with no command. A design that released itself would let translation resume over a faulted page. It then writes run in the same cycle as a fault; a design where the command won would lose the hold. It also clears a status bit in the same cycle as that bit's fault arrives; a design where clear won would drop an event. Separately, it checks that read, write and bus faults each land in their own capture register; a wrong mapping would hand software the wrong address. It also checks that the configuration mask, the command bit of the flush writes, invalid control codes and the read-only revision register each filter what they should. A design that got any of these wrong would store dropped bits, raise spurious invalidations or let a stray control value change the mode.

// File: rtl/xlt_regs_pkg.sv
package xlt_regs_pkg;

  localparam logic [7:0] OFS_CTRL    = 8'h00;
  localparam logic [7:0] OFS_CFG     = 8'h04;
  localparam logic [7:0] OFS_STAT    = 8'h08;
  localparam logic [7:0] OFS_FLALL   = 8'h0C;
  localparam logic [7:0] OFS_FLONE   = 8'h10;
  localparam logic [7:0] OFS_PTBASE  = 8'h14;
  localparam logic [7:0] OFS_INTST   = 8'h18;
  localparam logic [7:0] OFS_INTCLR  = 8'h1C;
  localparam logic [7:0] OFS_CAP0    = 8'h24;
  localparam logic [7:0] OFS_VER     = 8'h34;

  localparam logic [31:0] CMD_OFF  = 32'h0;
  localparam logic [31:0] CMD_RUN  = 32'h5;
  localparam logic [31:0] CMD_HOLD = 32'h7;

  localparam logic [31:0] CFG_KEEP = 32'h0150_FFFF;

  localparam int NUM_GRP = 4;

  typedef enum logic [1:0] {
    MODE_OFF,
    MODE_RUN,
    MODE_HOLD
  } mode_e;

  // Capture group of each fault bit; group g is read at OFS_CAP0 + 4*g.
  // 0: page fault, 1: write channel, 2: read channel, 3: bus error.
  function automatic logic [1:0] fault_group(input int idx);
    case (idx)
      0:       return 2'd0;
      1, 4, 5: return 2'd2;
      2, 6, 7: return 2'd1;
      default: return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/xlt_mode_ctl.sv
module xlt_mode_ctl
  import xlt_regs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic [DATA_W-1:0] ctrl_wdata,
  input  logic              fault_any,
  output logic              run_o,
  output logic              hold_o,
  output logic [DATA_W-1:0] code_o
);

  mode_e mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_OFF;
    end else if (fault_any) begin
      mode_q <= MODE_HOLD;
    end else if (ctrl_we) begin
      if (ctrl_wdata == DATA_W'(CMD_RUN))       mode_q <= MODE_RUN;
      else if (ctrl_wdata == DATA_W'(CMD_HOLD)) mode_q <= MODE_HOLD;
      else if (ctrl_wdata == DATA_W'(CMD_OFF))  mode_q <= MODE_OFF;
    end
  end

  assign run_o  = (mode_q == MODE_RUN);
  assign hold_o = (mode_q == MODE_HOLD);

  always_comb begin
    case (mode_q)
      MODE_RUN:  code_o = DATA_W'(CMD_RUN);
      MODE_HOLD: code_o = DATA_W'(CMD_HOLD);
      default:   code_o = DATA_W'(CMD_OFF);
    endcase
  end

  // R3: a hold command is visible on the next cycle
  p_hold_cmd_r3: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && ctrl_wdata == DATA_W'(CMD_HOLD) && !fault_any) |=> hold_o);

  // R11: a fault event always lands in held mode
  p_fault_holds_r11: assert property (@(posedge clk) disable iff (rst)
    fault_any |=> hold_o);

  // R11: held mode is only left through a control write
  p_hold_sticks_r11: assert property (@(posedge clk) disable iff (rst)
    (hold_o && !ctrl_we) |=> hold_o);

  // R2: run and held are exclusive
  p_mode_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(run_o && hold_o));

endmodule

// File: rtl/xlt_fault_log.sv
module xlt_fault_log
  import xlt_regs_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NUM_FAULTS = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_FAULTS-1:0]            fault_vld,
  input  logic [DATA_W-1:0]                fault_addr,
  input  logic                             clr_we,
  input  logic [NUM_FAULTS-1:0]            clr_bits,
  output logic [NUM_FAULTS-1:0]            status_o,
  output logic                             irq_o,
  output logic [NUM_GRP-1:0][DATA_W-1:0]   cap_o
);

  logic [NUM_FAULTS-1:0] status_q;
  logic [NUM_FAULTS-1:0] status_nxt;
  logic [NUM_FAULTS-1:0] clr_eff;
  logic                  irq_q;

  assign clr_eff    = clr_we ? clr_bits : '0;
  assign status_nxt = (status_q & ~clr_eff) | fault_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_nxt;
      irq_q    <= |status_nxt;
    end
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_cap
    logic [NUM_FAULTS-1:0] sel;
    logic [DATA_W-1:0]     addr_q;

    for (genvar b = 0; b < NUM_FAULTS; b++) begin : g_sel
      assign sel[b] = fault_vld[b] && (fault_group(b) == 2'(g));
    end

    always_ff @(posedge clk) begin
      if (rst)       addr_q <= '0;
      else if (|sel) addr_q <= fault_addr;
    end

    assign cap_o[g] = addr_q;
  end

  // R8: interrupt line tracks the status register
  p_irq_tracks_r8: assert property (@(posedge clk) disable iff (rst)
    irq_o == (status_q != '0));

  // R8: status bits stay set without a clear
  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    !clr_we |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R9: a cleared bit with no new event reads zero next cycle
  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (clr_we && fault_vld == '0) |=> ((status_q & $past(clr_bits)) == '0));

  // R9: a fresh event is never lost
  p_event_set_r9: assert property (@(posedge clk) disable iff (rst)
    (fault_vld != '0) |=> ((status_q & $past(fault_vld)) == $past(fault_vld)));

endmodule

// File: rtl/xlt_flush_gen.sv
module xlt_flush_gen #(
  parameter int DATA_W     = 32,
  parameter int PAGE_SHIFT = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       all_we,
  input  logic                       one_we,
  input  logic                       cmd_bit,
  input  logic [DATA_W-PAGE_SHIFT-1:0] page_num,
  output logic                       all_o,
  output logic                       one_o,
  output logic [DATA_W-1:0]          one_addr_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      all_o      <= 1'b0;
      one_o      <= 1'b0;
      one_addr_o <= '0;
    end else begin
      all_o <= all_we && cmd_bit;
      one_o <= one_we && cmd_bit;
      if (one_we && cmd_bit) one_addr_o <= {page_num, {PAGE_SHIFT{1'b0}}};
    end
  end

  // R6: a flush-all pulse only follows a flush-all command
  p_all_cause_r6: assert property (@(posedge clk) disable iff (rst)
    all_o |-> $past(all_we && cmd_bit));

  // R7: single-entry address is page aligned whenever pulsed
  p_one_align_r7: assert property (@(posedge clk) disable iff (rst)
    one_o |-> (one_addr_o[PAGE_SHIFT-1:0] == '0));

endmodule

// File: rtl/xlt_ctl_regs.sv
module xlt_ctl_regs
  import xlt_regs_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int NUM_FAULTS = 8,
  parameter int VER_MAJOR  = 3,
  parameter int VER_MINOR  = 3,
  parameter int PAGE_SHIFT = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wen,
  input  logic                  reg_ren,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  input  logic [NUM_FAULTS-1:0] fault_vld,
  input  logic [DATA_W-1:0]     fault_addr,
  output logic                  xlt_run,
  output logic                  xlt_held,
  output logic [DATA_W-1:0]     pt_base,
  output logic                  cfg_lru,
  output logic [3:0]            cfg_qos,
  output logic                  flush_all,
  output logic                  flush_one,
  output logic [DATA_W-1:0]     flush_one_addr,
  output logic                  irq
);

  localparam int VER_BITS = 11;
  localparam logic [VER_BITS-1:0] VER_CODE = {4'(VER_MAJOR), 7'(VER_MINOR)};
  localparam logic [DATA_W-1:0] VER_WORD =
    DATA_W'(VER_CODE) << (DATA_W - VER_BITS);

  logic we_ctrl, we_cfg, we_flall, we_flone, we_pt, we_clr;
  logic [DATA_W-1:0] cfg_q, pt_q, mode_code;
  logic [NUM_FAULTS-1:0] int_status;
  logic [NUM_GRP-1:0][DATA_W-1:0] cap;
  logic [DATA_W-1:0] rd_mux, rdata_q;

  assign we_ctrl  = reg_wen && reg_addr == ADDR_W'(OFS_CTRL);
  assign we_cfg   = reg_wen && reg_addr == ADDR_W'(OFS_CFG);
  assign we_flall = reg_wen && reg_addr == ADDR_W'(OFS_FLALL);
  assign we_flone = reg_wen && reg_addr == ADDR_W'(OFS_FLONE);
  assign we_pt    = reg_wen && reg_addr == ADDR_W'(OFS_PTBASE);
  assign we_clr   = reg_wen && reg_addr == ADDR_W'(OFS_INTCLR);

  xlt_mode_ctl #(.DATA_W(DATA_W)) u_mode (
    .clk        (clk),
    .rst        (rst),
    .ctrl_we    (we_ctrl),
    .ctrl_wdata (reg_wdata),
    .fault_any  (|fault_vld),
    .run_o      (xlt_run),
    .hold_o     (xlt_held),
    .code_o     (mode_code)
  );

  xlt_fault_log #(.DATA_W(DATA_W), .NUM_FAULTS(NUM_FAULTS)) u_flog (
    .clk        (clk),
    .rst        (rst),
    .fault_vld  (fault_vld),
    .fault_addr (fault_addr),
    .clr_we     (we_clr),
    .clr_bits   (reg_wdata[NUM_FAULTS-1:0]),
    .status_o   (int_status),
    .irq_o      (irq),
    .cap_o      (cap)
  );

  xlt_flush_gen #(.DATA_W(DATA_W), .PAGE_SHIFT(PAGE_SHIFT)) u_flush (
    .clk        (clk),
    .rst        (rst),
    .all_we     (we_flall),
    .one_we     (we_flone),
    .cmd_bit    (reg_wdata[0]),
    .page_num   (reg_wdata[DATA_W-1:PAGE_SHIFT]),
    .all_o      (flush_all),
    .one_o      (flush_one),
    .one_addr_o (flush_one_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      pt_q  <= '0;
    end else begin
      if (we_cfg) cfg_q <= reg_wdata & DATA_W'(CFG_KEEP);
      if (we_pt)  pt_q  <= reg_wdata;
    end
  end

  assign pt_base = pt_q;
  assign cfg_lru = cfg_q[0];
  assign cfg_qos = cfg_q[10:7];

  always_comb begin
    rd_mux = '0;
    if (reg_addr == ADDR_W'(OFS_CTRL))        rd_mux = mode_code;
    else if (reg_addr == ADDR_W'(OFS_CFG))    rd_mux = cfg_q;
    else if (reg_addr == ADDR_W'(OFS_STAT))   rd_mux = DATA_W'(xlt_held);
    else if (reg_addr == ADDR_W'(OFS_PTBASE)) rd_mux = pt_q;
    else if (reg_addr == ADDR_W'(OFS_INTST))  rd_mux = DATA_W'(int_status);
    else if (reg_addr == ADDR_W'(OFS_VER))    rd_mux = VER_WORD;
    else begin
      for (int g = 0; g < NUM_GRP; g++) begin
        if (reg_addr == ADDR_W'(OFS_CAP0) + ADDR_W'(4 * g)) rd_mux = cap[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (reg_ren) rdata_q <= rd_mux;
  end

  assign reg_rdata = rdata_q;

  // R4: stored configuration never holds bits outside the mask
  p_cfg_mask_r4: assert property (@(posedge clk) disable iff (rst)
    (cfg_q & ~DATA_W'(CFG_KEEP)) == '0);

  // R12: revision read always returns the fixed word
  p_ver_read_r12: assert property (@(posedge clk) disable iff (rst)
    (reg_ren && reg_addr == ADDR_W'(OFS_VER)) |=> reg_rdata == VER_WORD);

  // R13: unmapped or write-only offsets read zero
  p_zero_read_r13: assert property (@(posedge clk) disable iff (rst)
    (reg_ren && (reg_addr == ADDR_W'(OFS_FLALL) || reg_addr == ADDR_W'(OFS_INTCLR)))
      |=> reg_rdata == '0);

endmodule

// File: tb/xlt_ctl_regs_tb.sv
`timescale 1ns/1ps
module xlt_ctl_regs_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wen = 1'b0, reg_ren = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [7:0]  fault_vld = '0;
  logic [31:0] fault_addr = '0;
  logic        xlt_run, xlt_held, cfg_lru, flush_all, flush_one, irq;
  logic [3:0]  cfg_qos;
  logic [31:0] pt_base, flush_one_addr;

  always #2.5 clk = ~clk;

  xlt_ctl_regs u_dut (
    .clk(clk), .rst(rst), .reg_wen(reg_wen), .reg_ren(reg_ren),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fault_vld(fault_vld), .fault_addr(fault_addr),
    .xlt_run(xlt_run), .xlt_held(xlt_held), .pt_base(pt_base),
    .cfg_lru(cfg_lru), .cfg_qos(cfg_qos), .flush_all(flush_all),
    .flush_one(flush_one), .flush_one_addr(flush_one_addr), .irq(irq)
  );

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } rd_item_t;
  rd_item_t rdq[$];
  logic rd_seen = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= reg_ren;

  // monitor: compares each returned read word with the queued expectation
  always @(negedge clk) begin
    if (rd_seen && rdq.size() > 0) begin
      rd_item_t it;
      it = rdq.pop_front();
      chk(it.tag, reg_rdata, it.exp);
    end
  end

  task automatic drive(input logic w, input logic [7:0] a, input logic [31:0] d,
                       input logic [7:0] f, input logic [31:0] fa);
    @(negedge clk);
    reg_wen = w; reg_addr = a; reg_wdata = d; fault_vld = f; fault_addr = fa;
    @(negedge clk);
    reg_wen = 1'b0; fault_vld = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    drive(1'b1, a, d, 8'h0, 32'h0);
  endtask

  task automatic flt(input logic [7:0] f, input logic [31:0] fa);
    drive(1'b0, 8'h0, 32'h0, f, fa);
  endtask

  // driver: issues a read and pushes its expected word
  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    rd_item_t it;
    @(negedge clk);
    reg_ren = 1'b1; reg_addr = a;
    it.exp = exp; it.tag = tag;
    rdq.push_back(it);
    @(negedge clk);
    reg_ren = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(8'h00, 32'h0, "R1 ctrl");
    rd(8'h08, 32'h0, "R1 status");
    rd(8'h04, 32'h0, "R1 cfg");
    rd(8'h14, 32'h0, "R1 ptbase");
    rd(8'h18, 32'h0, "R1 intst");
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 run", {31'b0, xlt_run}, 32'h0);

    // R2 control codes
    wr(8'h00, 32'h5);
    chk("R2 run on", {31'b0, xlt_run}, 32'h1);
    rd(8'h00, 32'h5, "R2 ctrl run");
    wr(8'h00, 32'h3);
    rd(8'h00, 32'h5, "R2 invalid ignored");
    chk("R2 still run", {31'b0, xlt_run}, 32'h1);
    // R3 hold command
    wr(8'h00, 32'h7);
    chk("R3 held", {31'b0, xlt_held}, 32'h1);
    rd(8'h08, 32'h1, "R3 status held");
    rd(8'h00, 32'h7, "R2 ctrl hold");
    wr(8'h00, 32'h0);
    rd(8'h00, 32'h0, "R2 ctrl off");
    rd(8'h08, 32'h0, "R3 status clear");

    // R4 configuration mask and fields
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, 32'h0150_FFFF, "R4 masked");
    chk("R4 lru", {31'b0, cfg_lru}, 32'h1);
    chk("R4 qos", {28'b0, cfg_qos}, 32'hF);
    wr(8'h04, 32'h0000_0580);
    chk("R4 qos2", {28'b0, cfg_qos}, 32'hB);
    chk("R4 lru2", {31'b0, cfg_lru}, 32'h0);

    // R5 page table base
    wr(8'h14, 32'h8765_4000);
    rd(8'h14, 32'h8765_4000, "R5 ptbase");
    chk("R5 out", pt_base, 32'h8765_4000);

    // R6 flush all
    wr(8'h0C, 32'h1);
    chk("R6 pulse", {31'b0, flush_all}, 32'h1);
    @(negedge clk);
    chk("R6 one cycle", {31'b0, flush_all}, 32'h0);
    wr(8'h0C, 32'h2);
    chk("R6 no cmd bit", {31'b0, flush_all}, 32'h0);
    rd(8'h0C, 32'h0, "R13 flush reads zero");

    // R7 single entry flush
    wr(8'h10, 32'h1234_5ABD);
    chk("R7 pulse", {31'b0, flush_one}, 32'h1);
    chk("R7 addr", flush_one_addr, 32'h1234_5000);
    @(negedge clk);
    chk("R7 one cycle", {31'b0, flush_one}, 32'h0);
    wr(8'h10, 32'h1234_5ABC);
    chk("R7 no cmd bit", {31'b0, flush_one}, 32'h0);

    // R11 fault holds the unit; R8 status; R10 capture
    wr(8'h00, 32'h5);
    flt(8'h01, 32'hAAAA_0000);
    chk("R11 held after fault", {31'b0, xlt_held}, 32'h1);
    chk("R8 irq", {31'b0, irq}, 32'h1);
    repeat (20) @(negedge clk);
    chk("R11 stays held", {31'b0, xlt_held}, 32'h1);
    rd(8'h18, 32'h1, "R8 page bit");
    rd(8'h24, 32'hAAAA_0000, "R10 page addr");
    wr(8'h00, 32'h5);
    chk("R11 resume", {31'b0, xlt_run}, 32'h1);
    rd(8'h18, 32'h1, "R8 sticky after resume");
    wr(8'h1C, 32'h1);
    chk("R9 irq low", {31'b0, irq}, 32'h0);
    rd(8'h18, 32'h0, "R9 cleared");

    // R10 per-channel capture
    flt(8'h20, 32'h0000_1111);
    flt(8'h40, 32'h0000_2222);
    flt(8'h08, 32'h0000_3333);
    rd(8'h2C, 32'h0000_1111, "R10 read channel");
    rd(8'h28, 32'h0000_2222, "R10 write channel");
    rd(8'h30, 32'h0000_3333, "R10 bus error");
    rd(8'h18, 32'h68, "R8 multi bits");
    wr(8'h1C, 32'h08);
    rd(8'h18, 32'h60, "R9 partial clear");
    // R9 set wins over clear
    drive(1'b1, 8'h1C, 32'h20, 8'h20, 32'h0000_4444);
    rd(8'h18, 32'h60, "R9 set wins");
    rd(8'h2C, 32'h0000_4444, "R10 recapture");
    wr(8'h1C, 32'h60);
    rd(8'h18, 32'h0, "R9 all cleared");
    chk("R8 irq off", {31'b0, irq}, 32'h0);

    // R11 fault beats a run write in the same cycle
    drive(1'b1, 8'h00, 32'h5, 8'h02, 32'h0000_5555);
    chk("R11 fault wins", {31'b0, xlt_held}, 32'h1);
    wr(8'h00, 32'h0);
    chk("R11 off leaves hold", {31'b0, xlt_held}, 32'h0);
    wr(8'h1C, 32'hFF);

    // R12 revision, R13 unmapped
    rd(8'h34, 32'h3060_0000, "R12 version");
    wr(8'h34, 32'hFFFF_FFFF);
    rd(8'h34, 32'h3060_0000, "R12 write ignored");
    rd(8'h40, 32'h0, "R13 unmapped");
    rd(8'h1C, 32'h0, "R13 clear reads zero");

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule